// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Automatic Word Length

This block takes a standard I2S stream (bit clock, word select and serial data) and turns it into parallel stereo samples in the system clock domain. It does not need to be told the word width. It counts the bits in each channel slot, reports the length it found, and left-aligns every received word into a 24-bit sample. The unused low bits of the sample are set to zero.

The three serial inputs are asynchronous to the system clock. Each one passes through a multi-flop synchronizer. The bit clock is then oversampled, and its rising edges are detected inside the system domain. On each detected edge the block takes one data bit and the current word-select level. A pair of samples is released together with a single-cycle strobe once the right-channel word of a frame has ended.

Top module: `i2s_autolen_rx`

## Requirements
- R1: While reset is held, and after it is released, `valid_o` is 0 and `left_o`, `right_o` and `word_len_o` are all 0 until the first sample pair is released.
- R2: A word sent while word select is 0 appears on `left_o`. A word sent while word select is 1 appears on `right_o`.
- R3: Data and word select are sampled on bit clock rising edges only. The word's MSB is the bit one bit clock after a word-select change, and bits arrive MSB first. The bit sampled together with a changed word-select level is the LSB of the word that is ending.
- R4: A word of n bits, with 16 ≤ n ≤ 24, is placed in bits 23 down to 24−n of its output, and the remaining low bits are 0.
- R5: `word_len_o` gives the bit count of the right-channel word in the released pair. It updates in the same cycle as the samples.
- R6: If a slot carries more than 24 bits, the first 24 bits received are kept, the later bits are dropped, and `word_len_o` reports 24.
- R7: `valid_o` pulses for exactly one system clock cycle per stereo frame, after the right word ends. `left_o`, `right_o` and `word_len_o` change only in that cycle and hold their values between pulses.
- R8: After reset, no pair is released until both of these have been received: a complete left word that starts after a word-select change, and then the right word that follows it. Partial words seen at start-up are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Word select: 0 for left, 1 for right |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new pair is present |
| word_len_o | output | 5 | Detected word length (16 to 24) |

## Verification
The stream is driven at word lengths of 16, 20, 24 and 28 bits, with different left and right values in each frame:
- At 16 and 20 bits, correct alignment and zero fill are separated from misplaced or partial words.
- At 28 bits, truncation to the leading 24 bits is separated from keeping the trailing bits.
- A frame whose left word is a lone MSB and whose right word is a lone LSB catches an off-by-one in the one-bit delay or a reversed bit order.

A start-up sequence checks that exactly one pair comes out of the first two frames. A pulse-count check confirms one strobe per frame and stable outputs between strobes.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 8);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CNT_W-1:0]    bitcnt_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        sample_t data;
        bitcnt_t len;
        chan_e   chan;
    } slot_word_t;

    // Move an n-bit word, collected LSB-justified, up to the MSB end.
    function automatic sample_t left_align(sample_t raw, bitcnt_t n);
        if (n >= bitcnt_t'(SAMPLE_W))
            return raw;
        return raw << (bitcnt_t'(SAMPLE_W) - n);
    endfunction

    function automatic bitcnt_t clamp_len(bitcnt_t n);
        return (n > bitcnt_t'(SAMPLE_W)) ? bitcnt_t'(SAMPLE_W) : n;
    endfunction

endpackage

// File: rtl/i2s_in_sync.sv
module i2s_in_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[DEPTH-2:0], async_i};
    end

    assign sync_o = chain_q[DEPTH-1];

endmodule

// File: rtl/i2s_slot_rx.sv
module i2s_slot_rx
    import i2s_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bclk_i,
    input  logic       ws_i,
    input  logic       sd_i,
    output logic       done_o,
    output slot_word_t word_o
);

    logic    bclk_q;
    logic    ws_q;
    logic    armed_q;
    sample_t shift_q;
    bitcnt_t cnt_q;

    logic    rise;
    logic    ws_change;
    sample_t shift_n;
    bitcnt_t cnt_n;

    assign rise      = bclk_i & ~bclk_q;
    assign ws_change = ws_i ^ ws_q;

    always_comb begin
        shift_n = (cnt_q < bitcnt_t'(SAMPLE_W)) ? {shift_q[SAMPLE_W-2:0], sd_i} : shift_q;
        cnt_n   = (cnt_q == '1) ? cnt_q : cnt_q + bitcnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            ws_q    <= 1'b0;
            armed_q <= 1'b0;
            shift_q <= '0;
            cnt_q   <= '0;
            done_o  <= 1'b0;
            word_o  <= '0;
        end else begin
            bclk_q <= bclk_i;
            done_o <= 1'b0;
            if (rise) begin
                ws_q <= ws_i;
                if (ws_change) begin
                    // this bit is the LSB of the word that is closing
                    armed_q <= 1'b1;
                    shift_q <= '0;
                    cnt_q   <= '0;
                    if (armed_q) begin
                        done_o <= 1'b1;
                        word_o <= '{data: left_align(shift_n, cnt_n),
                                    len:  clamp_len(cnt_n),
                                    chan: chan_e'(ws_q)};
                    end
                end else begin
                    shift_q <= shift_n;
                    cnt_q   <= cnt_n;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_frame_pair.sv
module i2s_frame_pair
    import i2s_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done_i,
    input  slot_word_t word_i,
    output sample_t    left_o,
    output sample_t    right_o,
    output bitcnt_t    len_o,
    output logic       valid_o
);

    sample_t left_hold_q;
    logic    have_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold_q <= '0;
            have_left_q <= 1'b0;
            left_o      <= '0;
            right_o     <= '0;
            len_o       <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (done_i) begin
                if (word_i.chan == CH_LEFT) begin
                    left_hold_q <= word_i.data;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    left_o      <= left_hold_q;
                    right_o     <= word_i.data;
                    len_o       <= word_i.len;
                    valid_o     <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_autolen_rx.sv
module i2s_autolen_rx
    import i2s_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_i,
    input  logic                ws_i,
    input  logic                sd_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic [CNT_W-1:0]    word_len_o
);

    localparam int N_IN = 3;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] synced;
    slot_word_t      slot_word;
    logic            slot_done;

    assign raw_in = {bclk_i, ws_i, sd_i};

    i2s_in_sync #(
        .WIDTH (N_IN),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(raw_in),
        .sync_o (synced)
    );

    i2s_slot_rx u_slot (
        .clk   (clk),
        .rst   (rst),
        .bclk_i(synced[2]),
        .ws_i  (synced[1]),
        .sd_i  (synced[0]),
        .done_o(slot_done),
        .word_o(slot_word)
    );

    i2s_frame_pair u_pair (
        .clk    (clk),
        .rst    (rst),
        .done_i (slot_done),
        .word_i (slot_word),
        .left_o (left_o),
        .right_o(right_o),
        .len_o  (word_len_o),
        .valid_o(valid_o)
    );

endmodule

// File: rtl/i2s_rx_chk.sv
module i2s_rx_chk
    import i2s_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                valid_o,
    input logic [CNT_W-1:0]    word_len_o
);

    sample_t fill_mask;

    always_comb begin
        fill_mask = ~({SAMPLE_W{1'b1}} << (SAMPLE_W - int'(word_len_o)));
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(left_o) && $stable(right_o) && $stable(word_len_o)));

    a_r5_len_range: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (word_len_o <= CNT_W'(SAMPLE_W) && word_len_o != '0));

    a_r4_zero_fill: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (((left_o & fill_mask) == '0) && ((right_o & fill_mask) == '0)));

endmodule

bind i2s_autolen_rx i2s_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o),
    .word_len_o(word_len_o)
);

// File: tb/test_i2s_autolen_rx.sv
module test_i2s_autolen_rx;

    logic        clk  = 1'b0;
    logic        rst  = 1'b1;
    logic        bclk = 1'b0;
    logic        ws   = 1'b0;
    logic        sd   = 1'b0;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;
    logic [4:0]  word_len_o;

    int          checks = 0;
    int          errors = 0;
    int          vcount = 0;
    logic [23:0] cap_l = '0;
    logic [23:0] cap_r = '0;
    logic [4:0]  cap_len = '0;
    logic        carry = 1'b0;

    i2s_autolen_rx i_i2s_autolen_rx (
        .clk       (clk),
        .rst       (rst),
        .bclk_i    (bclk),
        .ws_i      (ws),
        .sd_i      (sd),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o),
        .word_len_o(word_len_o)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (!rst && valid_o) begin
            vcount  <= vcount + 1;
            cap_l   <= left_o;
            cap_r   <= right_o;
            cap_len <= word_len_o;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_align(input logic [31:0] w, input int n);
        logic [31:0] m;
        if (n >= 24) return 24'(w >> (n - 24));
        m = w & ((32'd1 << n) - 1);
        return 24'(m << (24 - n));
    endfunction

    // data and word select change while the bit clock is low
    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        bclk = 1'b0;
        ws   = w;
        sd   = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_slot(input logic w, input logic [31:0] word, input int n);
        send_bit(w, carry);
        for (int i = n - 1; i >= 1; i--) send_bit(w, word[i]);
        carry = word[0];
    endtask

    task automatic send_frame(input int n, input logic [31:0] l, input logic [31:0] r);
        send_slot(1'b0, l, n);
        send_slot(1'b1, r, n);
    endtask

    // send one frame, close it with a padding left slot, then check the pair
    task automatic frame_and_check(input string req, input int n,
                                   input logic [31:0] l, input logic [31:0] r);
        send_frame(n, l, r);
        send_slot(1'b0, 32'h0, n);
        chk(req, "left", 32'(cap_l), 32'(exp_align(l, n)));
        chk(req, "right", 32'(cap_r), 32'(exp_align(r, n)));
        chk(req, "len", 32'(cap_len), (n > 24) ? 32'd24 : 32'(n));
        send_slot(1'b1, 32'h0, n);
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        chk("R1", "valid in reset", 32'(valid_o), 32'd0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1", "left after reset", 32'(left_o), 32'd0);
        chk("R1", "right after reset", 32'(right_o), 32'd0);
        chk("R1", "len after reset", 32'(word_len_o), 32'd0);
        chk("R1", "no strobe", 32'(vcount), 32'd0);
    endtask

    task automatic t_startup;
        send_frame(24, 32'h111111, 32'h222222);
        send_frame(24, 32'hC0FFEE, 32'h5A5A5A);
        send_slot(1'b0, 32'h0, 24);
        chk("R8", "pairs after two frames", 32'(vcount), 32'd1);
        chk("R2", "left of second frame", 32'(cap_l), 32'hC0FFEE);
        chk("R2", "right of second frame", 32'(cap_r), 32'h5A5A5A);
        send_slot(1'b1, 32'h0, 24);
    endtask

    task automatic t_order;
        frame_and_check("R3", 24, 32'h800000, 32'h000001);
    endtask

    task automatic t_len24;
        frame_and_check("R2", 24, 32'h123456, 32'hFEDCBA);
    endtask

    task automatic t_len16;
        frame_and_check("R4", 16, 32'hA5C3, 32'h8001);
        frame_and_check("R5", 16, 32'h7FFF, 32'h0001);
    endtask

    task automatic t_len20;
        frame_and_check("R4", 20, 32'hFFFFF, 32'h00001);
    endtask

    task automatic t_len28;
        frame_and_check("R6", 28, 32'hABCDEF7, 32'h1234567);
    endtask

    task automatic t_pulse_count;
        int v0;
        v0 = vcount;
        frame_and_check("R7", 18, 32'h2AAAA, 32'h15555);
        // the padding pair from before plus this frame
        chk("R7", "strobes per frame", 32'(vcount - v0), 32'd2);
        repeat (40) @(negedge clk);
        chk("R7", "left held", 32'(left_o), 32'(exp_align(32'h2AAAA, 18)));
        chk("R7", "right held", 32'(right_o), 32'(exp_align(32'h15555, 18)));
    endtask

    initial begin
        #(100000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_startup();
        t_order();
        t_len24();
        t_len16();
        t_len20();
        t_len28();
        t_pulse_count();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule